// File: doc/BRIEF.md
# 16-bit Multicycle Processor Core

This block is a small multicycle CPU. It executes a 16-bit instruction set with eight 16-bit general registers. Every instruction goes through a shared fetch and decode pair of cycles. It then finishes in one to three more cycles, depending on its class. A single synchronous memory port carries both instruction fetches and data loads and stores.

The datapath holds these parts:
- the program counter
- an instruction register
- A and B operand latches and an ALU result latch
- a register file with two read ports and one write port
- an immediate sign extender
- the ALU

A sequencer selects the multiplexers and write enables through one control word in every state. The program counter holds a byte address and steps by 4. The memory word address is the byte address shifted right by two. A halt instruction freezes the core until reset.

Top module: `mc_cpu16`

## Requirements
- R1: After reset the core fetches from byte address 0. Each instruction starts with a fetch cycle that reads word PC>>2 and advances PC by 4, followed by a decode cycle.
- R2: Memory reads are synchronous: data is returned in the cycle after the address. A read and a write are never issued in the same cycle.
- R3: R-format is opcode[15:12], rs[11:9], rt[8:6], rd[5:3]. Opcodes 1, 2, 3 and 4 write rs AND rt, rs OR rt, rs+rt and rs-rt (modulo 2^16) to rd.
- R4: Opcode 10 (R-format) writes 1 to rd when rs < rt as signed values, else 0. Opcode 11 (I-format) writes 1 to rt when rs < sext(imm), else 0.
- R5: I-format is opcode[15:12], rs[11:9], rt[8:6], imm[5:0], with imm sign-extended (-32..31). Opcode 5 writes rs+sext(imm) to rt. Opcode 0 writes rs shifted left by imm[3:0] to rt.
- R6: Opcode 6 loads the memory word at byte address rs+sext(imm) into rt. Opcode 7 stores rt to that address.
- R7: Opcode 9 branches when rs equals rt, and opcode 8 when they differ. The target is the branch's address + 4 + sext(imm)*4; otherwise execution continues at address + 4.
- R8: J-format is opcode[15:12], target[11:0]. Opcode 12 jumps to target*4. Opcode 14 does the same and writes the jal's address + 4 to register 7. Opcode 13 jumps to the value of rs.
- R9: Opcode 15 stops all PC changes and memory accesses and raises halted_o, which stays high until reset.
- R10: Reset clears all registers to zero and holds halted_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | MEM_AW | Word address for fetch or data access |
| mem_re_o | output | 1 | Read strobe |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | XLEN | Store data |
| mem_rdata_i | input | XLEN | Read data, valid the cycle after the address |
| halted_o | output | 1 | Core has executed a halt |

## Verification
The hardest case to reach from the ports is a backward taken branch: only the sign-extended offset, scaled by four, can reach it. The same holds for the jal/jr pair, where the return address must survive a subroutine. Both are driven by small programs loaded into the bench memory. In one, a counted loop closes with a negative bne offset. In the other, a jal enters a subroutine that returns through jr on register 7, after which a forward j skips a poisoned store. Results are stored to memory before halting. The final memory image then shows the loop count, the skipped locations and the captured return address.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
  localparam int ILEN   = 16;
  localparam int NREG   = 8;
  localparam int RA_IDX = 7;

  typedef enum logic [3:0] {
    OP_SLL, OP_AND, OP_OR, OP_ADD, OP_SUB, OP_ADDI, OP_LW, OP_SW,
    OP_BNE, OP_BEQ, OP_SLT, OP_SLTI, OP_J, OP_JR, OP_JAL, OP_HALT
  } opcode_e;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_EXEC, S_WB, S_MADDR, S_MRD, S_MWB, S_MWR,
    S_BR, S_JMP, S_JR, S_JAL, S_HALT
  } state_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLL, ALU_SLT
  } alu_op_e;

  typedef enum logic       {ASEL_PC, ASEL_A} asel_e;
  typedef enum logic [1:0] {BSEL_B, BSEL_FOUR, BSEL_IMM, BSEL_IMM4} bsel_e;
  typedef enum logic [1:0] {PCS_ALU, PCS_ALUOUT, PCS_JUMP, PCS_REG} pcsel_e;
  typedef enum logic [1:0] {WB_ALUOUT, WB_MEM, WB_PC} wbsel_e;
  typedef enum logic [1:0] {DST_RT, DST_RD, DST_RA} dst_e;

  typedef struct packed {
    logic    pc_we;
    logic    br_en;
    logic    iord;
    logic    mem_re;
    logic    mem_we;
    logic    ir_we;
    logic    ab_we;
    logic    aluout_we;
    logic    reg_we;
    asel_e   asel;
    bsel_e   bsel;
    alu_op_e alu_op;
    pcsel_e  pcsel;
    wbsel_e  wbsel;
    dst_e    dst;
  } ctrl_t;

  function automatic logic is_rtype(opcode_e op);
    return op inside {OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT};
  endfunction

  function automatic alu_op_e alu_for(opcode_e op);
    case (op)
      OP_AND:          return ALU_AND;
      OP_OR:           return ALU_OR;
      OP_SUB:          return ALU_SUB;
      OP_SLT, OP_SLTI: return ALU_SLT;
      OP_SLL:          return ALU_SLL;
      default:         return ALU_ADD;
    endcase
  endfunction
endpackage

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  localparam int SHW = $clog2(W);

  always_comb begin
    case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLL: y_o = a_i << b_i[SHW-1:0];
      ALU_SLT: y_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: y_o = a_i + b_i;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int W = 16,
  parameter int N = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [$clog2(N)-1:0] ra_i,
  input  logic [$clog2(N)-1:0] rb_i,
  output logic [W-1:0]         da_o,
  output logic [W-1:0]         db_o,
  input  logic                 we_i,
  input  logic [$clog2(N)-1:0] wa_i,
  input  logic [W-1:0]         wd_i
);
  logic [W-1:0] regs_q [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        regs_q[g] <= '0;
      else if (we_i && wa_i == g[$clog2(N)-1:0]) regs_q[g] <= wd_i;
    end
  end

  assign da_o = regs_q[ra_i];
  assign db_o = regs_q[rb_i];

  // written value is visible one cycle later
  p_rf_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(wa_i)] == $past(wd_i));
endmodule

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
  import cpu16_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  opcode_e op_i,
  output ctrl_t   ctrl_o,
  output state_e  state_o
);
  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_FETCH;
    else         state_q <= state_d;
  end

  always_comb begin
    ctrl_o  = '0;
    state_d = state_q;
    case (state_q)
      S_FETCH: begin
        ctrl_o.mem_re = 1'b1;
        ctrl_o.asel   = ASEL_PC;
        ctrl_o.bsel   = BSEL_FOUR;
        ctrl_o.alu_op = ALU_ADD;
        ctrl_o.pc_we  = 1'b1;
        ctrl_o.pcsel  = PCS_ALU;
        state_d       = S_DECODE;
      end
      S_DECODE: begin
        // speculative branch target while operands are latched
        ctrl_o.ir_we     = 1'b1;
        ctrl_o.ab_we     = 1'b1;
        ctrl_o.asel      = ASEL_PC;
        ctrl_o.bsel      = BSEL_IMM4;
        ctrl_o.alu_op    = ALU_ADD;
        ctrl_o.aluout_we = 1'b1;
        case (op_i)
          OP_LW, OP_SW:   state_d = S_MADDR;
          OP_BNE, OP_BEQ: state_d = S_BR;
          OP_J:           state_d = S_JMP;
          OP_JR:          state_d = S_JR;
          OP_JAL:         state_d = S_JAL;
          OP_HALT:        state_d = S_HALT;
          default:        state_d = S_EXEC;
        endcase
      end
      S_EXEC: begin
        ctrl_o.asel      = ASEL_A;
        ctrl_o.bsel      = is_rtype(op_i) ? BSEL_B : BSEL_IMM;
        ctrl_o.alu_op    = alu_for(op_i);
        ctrl_o.aluout_we = 1'b1;
        state_d          = S_WB;
      end
      S_WB: begin
        ctrl_o.reg_we = 1'b1;
        ctrl_o.wbsel  = WB_ALUOUT;
        ctrl_o.dst    = is_rtype(op_i) ? DST_RD : DST_RT;
        state_d       = S_FETCH;
      end
      S_MADDR: begin
        ctrl_o.asel      = ASEL_A;
        ctrl_o.bsel      = BSEL_IMM;
        ctrl_o.alu_op    = ALU_ADD;
        ctrl_o.aluout_we = 1'b1;
        state_d          = (op_i == OP_LW) ? S_MRD : S_MWR;
      end
      S_MRD: begin
        ctrl_o.iord   = 1'b1;
        ctrl_o.mem_re = 1'b1;
        state_d       = S_MWB;
      end
      S_MWB: begin
        ctrl_o.reg_we = 1'b1;
        ctrl_o.wbsel  = WB_MEM;
        ctrl_o.dst    = DST_RT;
        state_d       = S_FETCH;
      end
      S_MWR: begin
        ctrl_o.iord   = 1'b1;
        ctrl_o.mem_we = 1'b1;
        state_d       = S_FETCH;
      end
      S_BR: begin
        ctrl_o.asel   = ASEL_A;
        ctrl_o.bsel   = BSEL_B;
        ctrl_o.alu_op = ALU_SUB;
        ctrl_o.br_en  = 1'b1;
        ctrl_o.pcsel  = PCS_ALUOUT;
        state_d       = S_FETCH;
      end
      S_JMP: begin
        ctrl_o.pc_we = 1'b1;
        ctrl_o.pcsel = PCS_JUMP;
        state_d      = S_FETCH;
      end
      S_JR: begin
        ctrl_o.pc_we = 1'b1;
        ctrl_o.pcsel = PCS_REG;
        state_d      = S_FETCH;
      end
      S_JAL: begin
        ctrl_o.pc_we  = 1'b1;
        ctrl_o.pcsel  = PCS_JUMP;
        ctrl_o.reg_we = 1'b1;
        ctrl_o.wbsel  = WB_PC;
        ctrl_o.dst    = DST_RA;
        state_d       = S_FETCH;
      end
      default: state_d = S_HALT;
    endcase
  end

  assign state_o = state_q;

  p_fetch_decode_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_FETCH |=> state_q == S_DECODE);
endmodule

// File: rtl/mc_cpu16.sv
module mc_cpu16
  import cpu16_pkg::*;
#(
  parameter int XLEN   = 16,
  parameter int MEM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  input  logic [XLEN-1:0]   mem_rdata_i,
  output logic              halted_o
);
  localparam int RAW = $clog2(NREG);
  localparam int IMW = 6;
  localparam int JTW = 12;

  ctrl_t  ctrl;
  state_e state;

  logic [XLEN-1:0] pc_q, a_q, b_q, aluout_q;
  logic [ILEN-1:0] ir_q, cur_ir;
  logic [XLEN-1:0] rf_a, rf_b, alu_a, alu_b, alu_y, pc_d, wb_data;
  logic [XLEN-1:0] imm_sx, imm_x4, jump_tgt;
  logic [RAW-1:0]  wa;
  logic            alu_zero, br_taken;
  opcode_e         op;

  // instruction word is taken straight from memory during decode
  assign cur_ir   = (state == S_DECODE) ? mem_rdata_i[ILEN-1:0] : ir_q;
  assign op       = opcode_e'(cur_ir[15:12]);
  assign imm_sx   = {{(XLEN-IMW){cur_ir[IMW-1]}}, cur_ir[IMW-1:0]};
  assign imm_x4   = {imm_sx[XLEN-3:0], 2'b00};
  assign jump_tgt = {{(XLEN-JTW-2){1'b0}}, cur_ir[JTW-1:0], 2'b00};

  cpu16_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .ctrl_o (ctrl),
    .state_o(state)
  );

  always_comb begin
    case (ctrl.dst)
      DST_RD:  wa = cur_ir[5:3];
      DST_RA:  wa = RAW'(RA_IDX);
      default: wa = cur_ir[8:6];
    endcase
    case (ctrl.wbsel)
      WB_MEM:  wb_data = mem_rdata_i;
      WB_PC:   wb_data = pc_q;
      default: wb_data = aluout_q;
    endcase
  end

  cpu16_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_i  (cur_ir[11:9]),
    .rb_i  (cur_ir[8:6]),
    .da_o  (rf_a),
    .db_o  (rf_b),
    .we_i  (ctrl.reg_we),
    .wa_i  (wa),
    .wd_i  (wb_data)
  );

  assign alu_a = (ctrl.asel == ASEL_A) ? a_q : pc_q;
  always_comb begin
    case (ctrl.bsel)
      BSEL_FOUR: alu_b = XLEN'(4);
      BSEL_IMM:  alu_b = imm_sx;
      BSEL_IMM4: alu_b = imm_x4;
      default:   alu_b = b_q;
    endcase
  end

  cpu16_alu #(.W(XLEN)) u_alu (
    .a_i   (alu_a),
    .b_i   (alu_b),
    .op_i  (ctrl.alu_op),
    .y_o   (alu_y),
    .zero_o(alu_zero)
  );

  assign br_taken = ctrl.br_en & (alu_zero ^ (op == OP_BNE));

  always_comb begin
    case (ctrl.pcsel)
      PCS_ALUOUT: pc_d = aluout_q;
      PCS_JUMP:   pc_d = jump_tgt;
      PCS_REG:    pc_d = a_q;
      default:    pc_d = alu_y;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      ir_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      if (ctrl.pc_we || br_taken) pc_q <= pc_d;
      if (ctrl.ir_we)             ir_q <= mem_rdata_i[ILEN-1:0];
      if (ctrl.ab_we) begin
        a_q <= rf_a;
        b_q <= rf_b;
      end
      if (ctrl.aluout_we)         aluout_q <= alu_y;
    end
  end

  assign mem_addr_o  = ctrl.iord ? aluout_q[MEM_AW+1:2] : pc_q[MEM_AW+1:2];
  assign mem_re_o    = ctrl.mem_re;
  assign mem_we_o    = ctrl.mem_we;
  assign mem_wdata_o = b_q;
  assign halted_o    = (state == S_HALT);

  p_pc_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == S_FETCH |=> pc_q == $past(pc_q) + XLEN'(4));
  p_mem_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  p_halt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(pc_q));
  p_halt_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_we_o && !mem_re_o);
endmodule

// File: tb/sim_mc_cpu16.sv
`timescale 1ns/1ps
module sim_mc_cpu16;
  localparam int XLEN   = 16;
  localparam int MEM_AW = 8;
  localparam int PLEN   = 80;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [MEM_AW-1:0] mem_addr;
  logic              mem_re, mem_we, halted;
  logic [XLEN-1:0]   mem_wdata, mem_rdata;

  logic [XLEN-1:0]   mem [0:(1<<MEM_AW)-1];
  logic              ld_en = 1'b0;
  logic [MEM_AW-1:0] ld_addr = '0;
  logic [XLEN-1:0]   ld_data = '0;
  logic [15:0]       prog [0:PLEN-1];

  int checks = 0, errors = 0, cycles = 0, post_halt_we = 0;

  always #2 clk = ~clk;

  mc_cpu16 #(.XLEN(XLEN), .MEM_AW(MEM_AW)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .mem_addr_o (mem_addr),
    .mem_re_o   (mem_re),
    .mem_we_o   (mem_we),
    .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata),
    .halted_o   (halted)
  );

  always @(posedge clk) begin
    if (ld_en)       mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (rst_ni && halted && mem_we) post_halt_we <= post_halt_we + 1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks + 1, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc_r(int op, int rs, int rt, int rd);
    return {op[3:0], rs[2:0], rt[2:0], rd[2:0], 3'b000};
  endfunction
  function automatic logic [15:0] enc_i(int op, int rs, int rt, int imm);
    return {op[3:0], rs[2:0], rt[2:0], imm[5:0]};
  endfunction
  function automatic logic [15:0] enc_j(int op, int tgt);
    return {op[3:0], tgt[11:0]};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < PLEN; i++) prog[i] = 16'h0000;
  endtask

  // load under reset, release, run until halt
  task automatic run_prog(input string tag);
    int n;
    rst_ni = 1'b0;
    for (int i = 0; i < PLEN; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = MEM_AW'(i); ld_data = prog[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    post_halt_we = 0;
    @(negedge clk);
    rst_ni = 1'b1;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!halted) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL R9 %s: act=no halt exp=halted", tag);
    end
  endtask

  // {opcode, rs value, rt value, imm, expected result}
  localparam logic [57:0] VECS [0:12] = '{
    {4'd1,  16'h0F0F, 16'h00FF, 6'h00, 16'h000F},  // and R3
    {4'd2,  16'h0F00, 16'h00F0, 6'h00, 16'h0FF0},  // or R3
    {4'd3,  16'h1234, 16'h0111, 6'h00, 16'h1345},  // add R3
    {4'd3,  16'hFFFF, 16'h0002, 6'h00, 16'h0001},  // add wrap R3
    {4'd4,  16'h0005, 16'h0007, 6'h00, 16'hFFFE},  // sub R3
    {4'd10, 16'hFFFE, 16'h0003, 6'h00, 16'h0001},  // slt R4
    {4'd10, 16'h0003, 16'hFFFE, 6'h00, 16'h0000},  // slt R4
    {4'd10, 16'h0005, 16'h0005, 6'h00, 16'h0000},  // slt equal R4
    {4'd11, 16'hFFE0, 16'h0000, 6'h21, 16'h0001},  // slti -32<-31 R4
    {4'd11, 16'h0014, 16'h0000, 6'h14, 16'h0000},  // slti 20<20 R4
    {4'd5,  16'h0100, 16'h0000, 6'h3F, 16'h00FF},  // addi -1 R5
    {4'd0,  16'h0001, 16'h0000, 6'h0F, 16'h8000},  // sll 15 R5
    {4'd0,  16'h00F3, 16'h0000, 6'h04, 16'h0F30}   // sll 4 R5
  };

  initial begin
    logic [MEM_AW-1:0] frozen;

    // reset state R10 / first fetch R1
    clear_prog();
    prog[0] = enc_i(15, 0, 0, 0);
    #1;
    check("R10 halted in reset", {15'd0, halted}, 16'h0000);
    check("R10 no write in reset", {15'd0, mem_we}, 16'h0000);
    run_prog("reset");
    check("R9 halted after halt", {15'd0, halted}, 16'h0001);
    rst_ni = 1'b0;
    #1;
    check("R10 halted clears", {15'd0, halted}, 16'h0000);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check("R1 first fetch addr", {8'd0, mem_addr}, 16'h0000);
    check("R1 first fetch read", {15'd0, mem_re}, 16'h0001);

    // ALU vectors; data words 64..66 via base register r6 = 256
    foreach (VECS[k]) begin
      logic [3:0] op;
      op = VECS[k][57:54];
      clear_prog();
      prog[0] = enc_i(5, 0, 6, 16);
      prog[1] = enc_i(0, 6, 6, 4);
      prog[2] = enc_i(6, 6, 1, 0);
      prog[3] = enc_i(6, 6, 2, 4);
      if (op == 4'd0 || op == 4'd5 || op == 4'd11)
        prog[4] = enc_i(int'(op), 1, 3, int'(VECS[k][21:16]));
      else
        prog[4] = enc_r(int'(op), 1, 2, 3);
      prog[5] = enc_i(7, 6, 3, 8);
      prog[6] = enc_i(15, 0, 0, 0);
      prog[64] = VECS[k][53:38];
      prog[65] = VECS[k][37:22];
      prog[66] = 16'hA5A5;
      run_prog("vec");
      check($sformatf("R3/R4/R5/R6 vector %0d op %0d", k, op), mem[66], VECS[k][15:0]);
    end

    // branches R7: taken forward, not taken, backward loop
    clear_prog();
    prog[0]  = enc_i(5, 0, 6, 16);
    prog[1]  = enc_i(0, 6, 6, 4);
    prog[2]  = enc_i(5, 0, 1, 5);
    prog[3]  = enc_i(5, 0, 2, 5);
    prog[4]  = enc_i(9, 1, 2, 1);     // beq -> word 6
    prog[5]  = enc_i(7, 6, 1, 0);     // skipped
    prog[6]  = enc_i(8, 1, 2, 1);     // bne not taken
    prog[7]  = enc_i(7, 6, 2, 4);
    prog[8]  = enc_i(5, 0, 4, 3);
    prog[9]  = enc_i(5, 5, 5, 2);
    prog[10] = enc_i(5, 4, 4, -1);
    prog[11] = enc_i(8, 4, 0, -3);    // back to word 9
    prog[12] = enc_i(7, 6, 5, 8);
    prog[13] = enc_i(15, 0, 0, 0);
    prog[64] = 16'hDEAD;
    prog[65] = 16'h0000;
    prog[66] = 16'h0000;
    run_prog("branch");
    check("R7 beq taken skips store", mem[64], 16'hDEAD);
    check("R7 bne not taken falls through", mem[65], 16'h0005);
    check("R7 backward bne loop count", mem[66], 16'h0006);

    // halt freeze R9
    frozen = mem_addr;
    repeat (20) @(negedge clk);
    check("R9 halted stays high", {15'd0, halted}, 16'h0001);
    check("R9 address frozen", {8'd0, mem_addr}, {8'd0, frozen});
    check("R9 no writes after halt", 16'(post_halt_we), 16'h0000);
    check("R2 no read after halt", {15'd0, mem_re}, 16'h0000);

    // jumps R8
    clear_prog();
    prog[0]  = enc_i(5, 0, 6, 16);
    prog[1]  = enc_i(0, 6, 6, 4);
    prog[2]  = enc_j(14, 10);         // jal -> word 10, r7 = 12
    prog[3]  = enc_i(7, 6, 1, 4);
    prog[4]  = enc_j(12, 12);         // j -> word 12
    prog[5]  = enc_i(7, 6, 6, 0);     // skipped
    prog[10] = enc_i(5, 0, 1, -7);
    prog[11] = enc_r(13, 7, 0, 0);    // jr r7
    prog[12] = enc_i(7, 6, 7, 8);
    prog[13] = enc_i(15, 0, 0, 0);
    prog[64] = 16'hBEEF;
    run_prog("jump");
    check("R8 jal/jr subroutine result", mem[65], 16'hFFF9);
    check("R8 j skips store", mem[64], 16'hBEEF);
    check("R8 jal link value", mem[66], 16'h000C);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule